// File: doc/BRIEF.md
# Programmable Shared-Interval Input Glitch Filter

This block cleans up to 32 digital input lines, grouped as four ports of eight lines. Every line first passes through a two-flop synchronizer. From there it reaches the output either directly (the raw path) or through a per-line stability filter (the filtered path). The filtered value moves to a new level only after the synchronized input has shown that level without interruption for a programmed time. Shorter pulses are dropped.

One 20-bit interval register sets the hold time for all filtered lines. It counts in units of a 200 ns time base, which a prescaler produces from the system clock. The clock rate is a parameter. Each port has its own 8-bit enable mask, which picks raw or filtered behaviour line by line. Software reaches both kinds of register through a simple write strobe and a combinational read port.

Top module: `glitch_filter_top`

## Requirements
- R1: After reset, the interval register and all four enable masks read as zero, and each output follows its synchronized input.
- R2: A write to address 0x08 loads the 20-bit interval. A write to address 0x44 + 0x10*p (p = 0..3) loads the enable mask of port p, where bit n controls line 8*p+n. Reads at these addresses return the stored value. Writes to any other address change nothing, and reads there return zero.
- R3: For a line whose enable bit is 0, the output equals the input delayed by exactly two clock cycles.
- R4: With the interval at 0, an enabled line behaves exactly like a disabled one: two cycles of delay and no filtering.
- R5: With interval N > 0, a pulse on an enabled line that lasts fewer than N*200 ns never reaches the output.
- R6: With interval N > 0, a new level on an enabled line does not reach the output sooner than N*200 ns after the input changes. It reaches the output no later than (N+1)*200 ns plus three cycles. A new interval value applies to every hold period that starts after the write.
- R7: Each line is filtered or passed raw according to its own enable bit alone, independently of its neighbours.
- R8: The prescaler issues a one-cycle tick every TICK_CYC = CLK_HZ*200 ns clock cycles, with no other ticks. The first tick comes TICK_CYC cycles after reset. A filtered output changes only at a tick.
- R9: While a line is disabled, its filter state tracks the raw value. Re-enabling the line therefore produces no transient, even if the filter had a change pending before it was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both write and read |
| wr_data | input | 20 | Register write data |
| rd_data | output | 20 | Combinational read data for `addr` |
| din | input | 32 | Raw input lines |
| dout | output | 32 | Filtered or raw output lines |

## Verification
The checker watches, on every cycle, that the prescaler ticks exactly once per period. It also confirms that enabled filtered outputs never change between ticks, that a write to the interval address lands in the interval register, and that reset leaves all registers clear. Only the bench scenarios can show the real timing windows. These are pulses one cycle shorter than the interval being rejected, held levels being accepted inside the upper bound, per-line independence across ports, the ignored writes at unmapped addresses, and the absence of a transient when a line with a pending change is disabled and then re-enabled.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int unsigned IVL_W       = 20;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned NPORTS      = 4;
  localparam logic [ADDR_W-1:0] IVL_ADDR    = 8'h08;
  localparam logic [ADDR_W-1:0] ENA_BASE    = 8'h44;
  localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h10;
endpackage

// File: rtl/gf_tick.sv
module gf_tick #(
  parameter int unsigned TICK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/gf_regs.sv
module gf_regs
  import gf_pkg::*;
#(
  parameter int unsigned NP = NPORTS,
  parameter int unsigned PW = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IVL_W-1:0]  wr_data,
  output logic [IVL_W-1:0]  rd_data,
  output logic [IVL_W-1:0]  ivl,
  output logic [NP*PW-1:0]  en
);
  logic [IVL_W-1:0]         ivl_q;
  logic                     ivl_hit;
  logic [NP-1:0][PW-1:0]    en_q;
  logic [NP-1:0]            en_hit;

  assign ivl_hit = (addr == IVL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ivl_q <= '0;
    else if (wr_en && ivl_hit)   ivl_q <= wr_data;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign en_hit[p] = (addr == ADDR_W'(ENA_BASE + p * PORT_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q[p] <= '0;
      else if (wr_en && en_hit[p]) en_q[p] <= wr_data[PW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (ivl_hit) rd_data = ivl_q;
    for (int p = 0; p < NP; p++) begin
      if (en_hit[p]) rd_data[PW-1:0] = en_q[p];
    end
  end

  assign ivl = ivl_q;
  assign en  = en_q;
endmodule

// File: rtl/gf_line.sv
module gf_line
  import gf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl,
  input  logic             tick,
  output logic             dout
);
  logic             s1_q, s2_q;
  logic             filt_q, filt_d;
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             active;

  assign active = en && (ivl != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!active) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else if (s2_q == filt_q) begin
      cnt_d  = '0;
    end else if (tick) begin
      if (cnt_q >= ivl) begin
        filt_d = s2_q;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout = active ? filt_q : s2_q;
endmodule

// File: rtl/glitch_filter_top.sv
module glitch_filter_top
  import gf_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned TICK_NS = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [IVL_W-1:0]         wr_data,
  output logic [IVL_W-1:0]         rd_data,
  input  logic [NPORTS*PORT_W-1:0] din,
  output logic [NPORTS*PORT_W-1:0] dout
);
  localparam int unsigned NLINES   = NPORTS * PORT_W;
  localparam int unsigned TICK_CYC = (CLK_HZ / 1_000_000) * TICK_NS / 1000;

  logic              rs1_q, rst_sync_n;
  logic              tick;
  logic [IVL_W-1:0]  ivl_q;
  logic [NLINES-1:0] en_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  gf_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  gf_regs #(.NP(NPORTS), .PW(PORT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ivl     (ivl_q),
    .en      (en_flat)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gf_line u_line (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (din[i]),
      .en    (en_flat[i]),
      .ivl   (ivl_q),
      .tick  (tick),
      .dout  (dout[i])
    );
  end
endmodule

// File: rtl/gf_checker.sv
module gf_checker
  import gf_pkg::*;
#(
  parameter int unsigned TICK_CYC = 40,
  parameter int unsigned NLINES   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [IVL_W-1:0]  ivl,
  input logic [NLINES-1:0] en,
  input logic [NLINES-1:0] dout,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [IVL_W-1:0]  wr_ivl
);
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  assert_tick_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == TICK_CYC - 1));

  assert_tick_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == TICK_CYC - 1) |-> tick);

  assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && (ivl != '0) && (ivl == $past(ivl)) && (en == $past(en)))
      |-> (((dout ^ $past(dout)) & en) == '0));

  assert_ivl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == IVL_ADDR)) |=> (ivl == $past(wr_ivl)));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((ivl == '0) && (en == '0)));
endmodule

bind glitch_filter_top gf_checker #(.TICK_CYC(TICK_CYC), .NLINES(NLINES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .tick   (tick),
  .ivl    (ivl_q),
  .en     (en_flat),
  .dout   (dout),
  .wr_en  (wr_en),
  .addr   (addr),
  .wr_ivl (wr_data)
);

// File: tb/glitch_filter_top_test.sv
module glitch_filter_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [19:0] wr_data;
  logic [19:0] rd_data;
  logic [31:0] din;
  logic [31:0] dout;

  int unsigned cyc = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned at;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  glitch_filter_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .din(din), .dout(dout)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int unsigned at, input logic [31:0] m,
                      input logic [31:0] v, input string tag);
    exp_t e;
    e.at = at; e.mask = m; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (sbq.size() != 0);
      e = sbq.pop_front();
      while (cyc < e.at) @(negedge clk);
      total++;
      if ((dout & e.mask) !== e.val) begin
        bad++;
        $display("FAIL %s cycle %0d: dout&mask=%h expected %h",
                 e.tag, cyc, dout & e.mask, e.val);
      end
    end
  end

  task automatic set_din(input logic [31:0] v, output int unsigned t);
    @(posedge clk); #1;
    din = v;
    t = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [19:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [19:0] exp, input string tag);
    addr = a;
    #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    int unsigned t, t2;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; din = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    // R1: reset state
    rd_chk(8'h08, 20'h0, "R1");
    rd_chk(8'h44, 20'h0, "R1");
    rd_chk(8'h74, 20'h0, "R1");
    push(cyc + 1, 32'hFFFF_FFFF, 32'h0, "R1");

    // R3: raw path, two-cycle delay
    set_din(32'hA5A5_0F0F, t);
    push(t + 1, 32'hFFFF_FFFF, 32'h0, "R3");
    push(t + 2, 32'hFFFF_FFFF, 32'hA5A5_0F0F, "R3");
    repeat (5) @(posedge clk);
    set_din(32'h0, t);
    repeat (5) @(posedge clk);

    // R2: register map, unmapped writes ignored
    wr(8'h08, 20'h12345);
    rd_chk(8'h08, 20'h12345, "R2");
    wr(8'h08, 20'h0);
    wr(8'h44, 20'h000FF);
    wr(8'h64, 20'h0000F);
    wr(8'h45, 20'h000AA);
    wr(8'h09, 20'h00777);
    rd_chk(8'h44, 20'h000FF, "R2");
    rd_chk(8'h64, 20'h0000F, "R2");
    rd_chk(8'h54, 20'h0, "R2");
    rd_chk(8'h45, 20'h0, "R2");
    rd_chk(8'h08, 20'h0, "R2");

    // R4: interval zero on enabled line behaves raw
    set_din(32'h0000_00FF, t);
    push(t + 1, 32'h0000_00FF, 32'h0, "R4");
    push(t + 2, 32'h0000_00FF, 32'h0000_00FF, "R4");
    repeat (5) @(posedge clk);
    set_din(32'h0, t);
    push(t + 2, 32'h0000_00FF, 32'h0, "R4");
    repeat (5) @(posedge clk);

    // R5: pulse of 79 cycles with interval 2 (80 cycles) rejected
    wr(8'h08, 20'd2);
    repeat (3) @(posedge clk);
    set_din(32'h0000_0101, t);
    push(t + 2,  32'h0000_0100, 32'h0000_0100, "R3");
    push(t + 40, 32'h0000_0001, 32'h0, "R5");
    push(t + 78, 32'h0000_0001, 32'h0, "R5");
    repeat (78) @(posedge clk);
    set_din(32'h0, t2);
    push(t2 + 60,  32'h0000_0001, 32'h0, "R5");
    push(t2 + 150, 32'h0000_0001, 32'h0, "R5");
    repeat (160) @(posedge clk);

    // R6/R8: held level accepted inside window
    set_din(32'h0000_0001, t);
    push(t + 80,  32'h0000_0001, 32'h0, "R6");
    push(t + 126, 32'h0000_0001, 32'h0000_0001, "R6");
    repeat (140) @(posedge clk);

    // R7: per-line selection across ports
    set_din(32'h0111_0001, t);
    push(t + 2,   32'h0110_0000, 32'h0110_0000, "R7");
    push(t + 40,  32'h0001_0000, 32'h0, "R7");
    push(t + 126, 32'h0111_0001, 32'h0111_0001, "R7");
    repeat (140) @(posedge clk);

    // R6: new interval applies to later hold periods
    wr(8'h08, 20'd1);
    rd_chk(8'h08, 20'd1, "R6");
    set_din(32'h0111_0005, t);
    push(t + 40, 32'h0000_0004, 32'h0, "R6");
    push(t + 86, 32'h0000_0004, 32'h0000_0004, "R6");
    repeat (100) @(posedge clk);

    // R9: disable with pending change, re-enable without transient
    set_din(32'h0111_0007, t);
    wr(8'h44, 20'h000FD);
    push(cyc + 3, 32'h0000_0002, 32'h0000_0002, "R9");
    repeat (5) @(posedge clk);
    wr(8'h44, 20'h000FF);
    push(cyc + 1,  32'h0000_0002, 32'h0000_0002, "R9");
    push(cyc + 20, 32'h0000_0002, 32'h0000_0002, "R9");
    repeat (30) @(posedge clk);

    wait (sbq.size() == 0);
    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule